// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block receives asynchronous serial frames from a single input line. A falling edge on the idle-high line is only a candidate start bit. The receiver waits half a bit time, samples the line again, and continues only if the line is still low. It then samples each data bit once, near the middle of its bit time, least significant bit first. An optional parity bit and a single stop bit follow.

At the end of every frame the received word is moved into a holding buffer and one interrupt pulse is raised. A clean frame raises a completion pulse. A frame with a parity, framing or overrun problem raises an error pulse instead. Parity and framing problems never cut a frame short. An overrun leaves the older, unread word in the buffer. All error flags stay set until software reads the buffer, which it signals with a one-cycle read strobe.

The receiver runs only after the power bit has been set and the receive-enable bit has been set afterwards.

Top module: `serial_rx_core`

## Requirements
- R1: Reception is armed only when `rx_en` rises while `power_en` was already high in the previous cycle. If both rise in the same cycle, nothing is armed. Dropping either bit disarms the receiver and returns it to idle.
- R2: `baud_div` gives the half-bit count H, valid from 2 to 31. The confirmation sample is taken H cycles after the cycle in which the falling edge is seen. Every later sample is taken 2H cycles after the one before it, so one bit lasts 2H clock cycles.
- R3: If the line is high at the confirmation sample, the edge is treated as a glitch. The receiver goes back to idle, reports nothing and waits for the next falling edge.
- R4: After a confirmed start bit, DATA_W data bits are received least significant bit first. If parity is enabled, one parity bit follows. One stop bit comes last.
- R5: When a frame completes, the buffer is written with the frame and `irq_done` pulses for exactly one cycle if no error occurred. Buffer and pulse appear two clock edges after the stop-bit sample.
- R6: `par_mode` selects the parity handling: 0 means no parity bit time; 1 means even (the data ones plus the parity bit must be even); 2 means odd; 3 means the parity bit time is sampled but never checked. A parity mismatch sets `err_stat[0]`.
- R7: A stop bit sampled low sets `err_stat[1]` (framing error). The data is still stored, and `irq_err` pulses instead of `irq_done`.
- R8: If a frame completes while an unread word is held, the buffer is left unchanged, `err_stat[2]` (overrun) is set and `irq_err` pulses.
- R9: A `rd_strobe` pulse empties the buffer and clears all of `err_stat`. Until such a read, the error bits stay set across later frames.
- R10: Only one stop bit is checked. A second stop bit is simply idle line, and a frame that follows it is received normally.
- R11: Driving `power_en` low clears `rx_buf` and `err_stat` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| power_en | input | 1 | Receiver power bit |
| rx_en | input | 1 | Receive enable, set after power |
| baud_div | input | DIV_W (5) | Half-bit count H |
| par_mode | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 unchecked |
| rxd | input | 1 | Serial input line, idle high |
| rd_strobe | input | 1 | Buffer read strobe |
| rx_buf | output | DATA_W (8) | Receive buffer |
| err_stat | output | 3 | Sticky errors: bit 2 overrun, bit 1 framing, bit 0 parity |
| irq_done | output | 1 | Clean completion pulse |
| irq_err | output | 1 | Error completion pulse |

## Verification
A bit counter or sample timer that is off by one moves the samples away from the bit centres. That shows up in `rx_buf` as data shifted by one bit, or as a false framing error on the very next frame. A stuck buffer-full or error flag shows in `err_stat` within one frame, either as an overrun after a read or as an error that does not clear. A wrong parity sense flips the `irq_done` / `irq_err` choice on the first frame in even or odd mode. An arming fault shows as frames that are accepted or lost when `power_en` and `rx_en` are raised together.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_FREE = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   localparam int ERR_PAR = 0;
   localparam int ERR_FRM = 1;
   localparam int ERR_OVR = 2;
   localparam int ERR_W   = 3;

endpackage

// File: rtl/srx_arm.sv
module srx_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic power_en,
   input  logic rx_en,
   output logic armed
);
   logic pwr_q;
   logic rxe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q <= 1'b0;
         rxe_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         pwr_q <= power_en;
         rxe_q <= rx_en;
         if (!power_en || !rx_en)
            armed <= 1'b0;
         else if (!rxe_q && pwr_q)
            armed <= 1'b1;
      end
   end

   AST_ARM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(pwr_q) && !$past(rxe_q)); // R1

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
   parameter int DIV_W = 5,
   localparam int CNT_W = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] half_div,
   output logic             at_half,
   output logic             at_full
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= CNT_W'(1);
      else if (run)
         cnt <= cnt + CNT_W'(1);
   end

   assign at_half = (cnt == {1'b0, half_div});
   assign at_full = (cnt == {half_div, 1'b0});

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit PAR_EN = 1'b1,
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic [1:0]        par_mode,
   input  logic              rxd,
   input  logic              at_half,
   input  logic              at_full,
   output logic              cnt_clr,
   output logic              cnt_run,
   output logic              frame_done,
   output logic [DATA_W-1:0] frame_data,
   output logic              par_err,
   output logic              frm_err
);
   rx_state_e         state;
   logic              rxd_prev;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              par_on;
   logic              par_bad;

   generate
      if (PAR_EN) begin : g_par
         par_mode_e mode;
         assign mode    = par_mode_e'(par_mode);
         assign par_on  = (mode != PAR_NONE);
         assign par_bad = (mode == PAR_EVEN) ? ( (^shreg) ^ par_bit) :
                          (mode == PAR_ODD)  ? ~((^shreg) ^ par_bit) : 1'b0;
      end else begin : g_nopar
         logic unused_mode;
         assign unused_mode = ^par_mode;
         assign par_on  = 1'b0;
         assign par_bad = 1'b0;
      end
   endgenerate

   assign cnt_run    = (state != ST_IDLE);
   assign frame_data = shreg;

   always_comb begin
      cnt_clr = 1'b0;
      case (state)
         ST_IDLE:  cnt_clr = armed && rxd_prev && !rxd;
         ST_START: cnt_clr = at_half;
         default:  cnt_clr = at_full;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         rxd_prev   <= 1'b1;
         idx        <= '0;
         shreg      <= '0;
         par_bit    <= 1'b0;
         frame_done <= 1'b0;
         par_err    <= 1'b0;
         frm_err    <= 1'b0;
      end else begin
         rxd_prev   <= rxd;
         frame_done <= 1'b0;
         if (!armed) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE:
                  if (rxd_prev && !rxd) state <= ST_START;
               ST_START:
                  if (at_half) begin
                     idx   <= '0;
                     state <= rxd ? ST_IDLE : ST_DATA;
                  end
               ST_DATA:
                  if (at_full) begin
                     shreg <= {rxd, shreg[DATA_W-1:1]};
                     if (idx == IDX_W'(DATA_W - 1))
                        state <= par_on ? ST_PAR : ST_STOP;
                     else
                        idx <= idx + IDX_W'(1);
                  end
               ST_PAR:
                  if (at_full) begin
                     par_bit <= rxd;
                     state   <= ST_STOP;
                  end
               ST_STOP:
                  if (at_full) begin
                     frame_done <= 1'b1;
                     frm_err    <= !rxd;
                     par_err    <= par_on && par_bad;
                     state      <= ST_IDLE;
                  end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && state == ST_START && at_half && rxd) |=> state == ST_IDLE); // R3
   AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> state == ST_IDLE); // R1
   AST_FRM_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> frm_err == !$past(rxd)); // R7

endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_en,
   input  logic              frame_done,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              par_err,
   input  logic              frm_err,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_buf,
   output logic [ERR_W-1:0]  err_stat,
   output logic              irq_done,
   output logic              irq_err
);
   logic full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full     <= 1'b0;
         rx_buf   <= '0;
         err_stat <= '0;
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
      end else begin
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
         if (!power_en) begin
            full     <= 1'b0;
            rx_buf   <= '0;
            err_stat <= '0;
         end else begin
            if (rd_strobe) begin
               full     <= 1'b0;
               err_stat <= '0;
            end
            if (frame_done) begin
               if (full && !rd_strobe) begin
                  err_stat[ERR_OVR] <= 1'b1;
                  irq_err           <= 1'b1;
               end else begin
                  rx_buf            <= frame_data;
                  full              <= 1'b1;
                  err_stat          <= '0;
                  err_stat[ERR_PAR] <= par_err;
                  err_stat[ERR_FRM] <= frm_err;
                  irq_done          <= !(par_err || frm_err);
                  irq_err           <= par_err || frm_err;
               end
            end
         end
      end
   end

   AST_OVR_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (power_en && full && frame_done && !rd_strobe) |=> $stable(rx_buf) && err_stat[ERR_OVR]); // R8
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !frame_done) |=> err_stat == '0); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done); // R5
   AST_PWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !power_en |=> rx_buf == '0 && err_stat == '0); // R11

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 5,
   parameter bit PAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_en,
   input  logic              rx_en,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic [1:0]        par_mode,
   input  logic              rxd,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_buf,
   output logic [2:0]        err_stat,
   output logic              irq_done,
   output logic              irq_err
);
   initial begin
      assert (DATA_W >= 5 && DATA_W <= 9) else $fatal(1, "DATA_W out of range");
      assert (DIV_W >= 2 && DIV_W <= 8) else $fatal(1, "DIV_W out of range");
   end

   logic              armed;
   logic              cnt_clr;
   logic              cnt_run;
   logic              at_half;
   logic              at_full;
   logic              frame_done;
   logic [DATA_W-1:0] frame_data;
   logic              par_err;
   logic              frm_err;

   srx_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .power_en (power_en),
      .rx_en    (rx_en),
      .armed    (armed)
   );

   srx_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (cnt_run),
      .clr      (cnt_clr),
      .half_div (baud_div),
      .at_half  (at_half),
      .at_full  (at_full)
   );

   srx_frame_fsm #(.DATA_W(DATA_W), .PAR_EN(PAR_EN)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed      (armed),
      .par_mode   (par_mode),
      .rxd        (rxd),
      .at_half    (at_half),
      .at_full    (at_full),
      .cnt_clr    (cnt_clr),
      .cnt_run    (cnt_run),
      .frame_done (frame_done),
      .frame_data (frame_data),
      .par_err    (par_err),
      .frm_err    (frm_err)
   );

   srx_rx_buffer #(.DATA_W(DATA_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_en   (power_en),
      .frame_done (frame_done),
      .frame_data (frame_data),
      .par_err    (par_err),
      .frm_err    (frm_err),
      .rd_strobe  (rd_strobe),
      .rx_buf     (rx_buf),
      .err_stat   (err_stat),
      .irq_done   (irq_done),
      .irq_err    (irq_err)
   );

endmodule

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
   localparam int H     = 4;
   localparam int LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       power_en = 1'b0;
   logic       rx_en = 1'b0;
   logic [4:0] baud_div = 5'(H);
   logic [1:0] par_mode = 2'd0;
   logic       rxd = 1'b1;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_buf;
   logic [2:0] err_stat;
   logic       irq_done;
   logic       irq_err;

   int n_chk = 0;
   int n_bad = 0;
   int n_done = 0;
   int n_err = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   serial_rx_core dut_i (
      .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en),
      .baud_div(baud_div), .par_mode(par_mode), .rxd(rxd),
      .rd_strobe(rd_strobe), .rx_buf(rx_buf), .err_stat(err_stat),
      .irq_done(irq_done), .irq_err(irq_err)
   );

   always @(posedge clk) begin
      if (irq_done) n_done <= n_done + 1;
      if (irq_err)  n_err  <= n_err + 1;
      cyc <= cyc + 1;
      if (cyc == LIMIT) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, LIMIT);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic par_of(input logic [7:0] d, input logic [1:0] m);
      case (m)
         2'd1:    return ^d;
         2'd2:    return ~(^d);
         default: return 1'b0;
      endcase
   endfunction

   task automatic hold_bit(input logic v);
      rxd = v;
      repeat (2 * H) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic bad_par,
                       input logic bad_stop, input logic two_stop);
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      if (par_mode != 2'd0) begin
         if (par_mode == 2'd3) hold_bit(1'($urandom_range(0, 1)));
         else hold_bit(par_of(d, par_mode) ^ bad_par);
      end
      hold_bit(!bad_stop);
      if (two_stop) hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic do_read;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic arm_in_order;
      power_en = 1'b1;
      @(negedge clk);
      rx_en = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      int d0, e0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset buf", rx_buf, 0);
      chk("R11 reset err", err_stat, 0);

      // R1: both bits raised together does not arm
      power_en = 1'b1; rx_en = 1'b1;
      @(negedge clk);
      d0 = n_done; e0 = n_err;
      send(8'hA5, 1'b0, 1'b0, 1'b0);
      chk("R1 same-cycle arm no irq", (n_done - d0) + (n_err - e0), 0);
      chk("R1 same-cycle arm no data", rx_buf, 0);
      power_en = 1'b0; rx_en = 1'b0;
      @(negedge clk);
      arm_in_order();

      // R3: short glitch is ignored, then a frame is received
      d0 = n_done; e0 = n_err;
      rxd = 1'b0; repeat (2) @(negedge clk);
      rxd = 1'b1; repeat (4 * H) @(negedge clk);
      chk("R3 glitch no irq", (n_done - d0) + (n_err - e0), 0);
      send(8'h3C, 1'b0, 1'b0, 1'b0);
      chk("R3 frame after glitch R4", rx_buf, 8'h3C);
      chk("R5 done pulse count", n_done - d0, 1);
      do_read();

      // R8 and R9: overrun keeps the old word and sticks until read
      send(8'h81, 1'b0, 1'b0, 1'b0);
      e0 = n_err;
      send(8'h7E, 1'b0, 1'b0, 1'b0);
      chk("R8 overrun buf kept", rx_buf, 8'h81);
      chk("R8 overrun flag", err_stat, 3'b100);
      chk("R8 overrun irq_err", n_err - e0, 1);
      send(8'h11, 1'b0, 1'b0, 1'b0);
      chk("R9 flag sticky", err_stat, 3'b100);
      do_read();
      chk("R9 read clears", err_stat, 0);
      send(8'h22, 1'b0, 1'b0, 1'b0);
      chk("R9 write after read", rx_buf, 8'h22);
      do_read();

      // R10: two stop bits then a back-to-back frame
      send(8'hF0, 1'b0, 1'b0, 1'b1);
      chk("R10 first frame", rx_buf, 8'hF0);
      do_read();
      send(8'h0F, 1'b0, 1'b0, 1'b0);
      chk("R10 second frame", rx_buf, 8'h0F);
      chk("R10 no error", err_stat, 0);

      // R11: power drop clears buffer and flags
      power_en = 1'b0; rx_en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 power clears buf", rx_buf, 0);
      chk("R11 power clears err", err_stat, 0);
      arm_in_order();

      // R2/R4/R6/R7: random frames, modes and errors
      for (int k = 0; k < 60; k++) begin
         logic [7:0] d;
         logic bp, bs, pe;
         d  = 8'($urandom);
         par_mode = 2'($urandom_range(0, 3));
         bp = ($urandom_range(0, 3) == 0);
         bs = ($urandom_range(0, 7) == 0);
         pe = bp && (par_mode == 2'd1 || par_mode == 2'd2);
         d0 = n_done; e0 = n_err;
         send(d, bp, bs, 1'b0);
         chk("R4 data", rx_buf, d);
         chk("R6 R7 flags", err_stat, {1'b0, bs, pe});
         chk("R5 done irq", n_done - d0, (pe || bs) ? 0 : 1);
         chk("R7 err irq", n_err - e0, (pe || bs) ? 1 : 0);
         do_read();
         chk("R9 cleared", err_stat, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule